// File: doc/BRIEF.md
# Event Status and Service Request Reporter

This block keeps the standard event status register of an IEEE 488.2 style instrument, together with its enable mask, the status byte summary, the service request enable mask and the power-on clear flag. Single-cycle event pulses from the rest of the instrument become sticky bits. The masked OR of those bits is the event summary in the status byte. The masked OR of the status byte, leaving out bit 6, drives the service request line.

Software reaches the three settings through one register write/read port, selected by a two-bit code. It empties the event register through a destructive read strobe. A power-up completion pulse restores both masks from a retained copy that ignores reset. If the power-on clear flag is set, the pulse zeroes both masks instead. Because the masks can survive a power cycle, a power-on event can raise a service request with no setup after the cycle.

Top module: `event_status_unit`

## Requirements
- R1: Event bits 0 to 5 (0 operation complete, 1 request control, 2 query error, 3 device error, 4 execution error, 5 command error) are each set one cycle after a one-cycle pulse on `evtPulse[i]`, and stay set until a destructive read.
- R2: Event bit 6 (user request) always reads as zero.
- R3: Event bit 7 (power on) is set only by a `powerUpDone` pulse with both `selftestOk` and `manualMode` high. A failed selftest or `manualMode` low leaves it clear.
- R4: With the power-on clear flag at 1, a `powerUpDone` pulse zeroes both masks. A following power-on event then raises neither status byte bit 5 nor `srq`.
- R5: With the power-on clear flag at 0, a `powerUpDone` pulse loads both masks with the last values written before the reset. Reset alone clears the live masks to zero.
- R6: `statusByte[5]` is the OR of the event register ANDed bitwise with the event enable mask.
- R7: `srq` is high whenever `statusByte[5]` and service enable bit 5 are both 1.
- R8: While `evtRdEn` is high, `evtRdData` shows the current event value, and the register clears at that edge. A pulse in the same cycle leaves its bit set after the read.
- R9: `statusByte[6]` is the OR of the other status byte bits ANDed with the service enable mask. Service enable bit 6 is ignored and reads as 0. Status byte bits 0–4 and 7 come from `sbExtBits`.
- R10: `srq` falls once no enabled summary condition remains, after a read of the event register or after a mask bit is cleared.
- R11: Register port codes for `regSel`: 0 is the event enable mask, 1 is the service enable mask, 2 is the power-on clear flag (data bit 0), and 3 reads 0 and ignores writes. `regRdData` follows `regSel` combinationally, and a write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power cycle) |
| evtPulse | input | 6 | Event pulses, bit i sets event bit i |
| powerUpDone | input | 1 | One-cycle pulse at end of power-up |
| selftestOk | input | 1 | Selftest passed, qualifies power-up |
| manualMode | input | 1 | Unit defaulted to manual mode |
| regWrEn | input | 1 | Setting write strobe |
| regSel | input | 2 | Setting select code |
| regWrData | input | 8 | Setting write data |
| regRdData | output | 8 | Selected setting value |
| evtRdEn | input | 1 | Destructive event read strobe |
| evtRdData | output | 8 | Event register value |
| sbExtBits | input | 8 | External status byte bits (5 and 6 unused) |
| statusByte | output | 8 | Status byte |
| srq | output | 1 | Service request |

## Verification
Several properties are checked on every cycle: that a command error pulse lands in its bit, that set bits stay set without a read, and that a read with no pulse empties the register. The same checks cover the choice between mask restore and mask zeroing at power-up, that bit 7 rises only after a qualified power-up, and that `srq` follows status bit 5 when it is enabled. The masks surviving a reset and then reappearing only at the power-up pulse can only be shown by the bench's power-cycle scenarios. The same holds for a pulse colliding with a read, and for bit 6 of the service mask having no effect.

// File: rtl/evtstat_pkg.sv
package evtstat_pkg;
  localparam int REG_W   = 8;
  localparam int N_PULSE = 6;
  localparam int SEL_W   = 2;
  localparam int URQ_BIT = 6;
  localparam int PON_BIT = 7;
  localparam int ESB_BIT = 5;
  localparam int MSS_BIT = 6;
  localparam logic [SEL_W-1:0] SEL_ESE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SRE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PSC = 2'd2;
  localparam logic [REG_W-1:0] MSS_MASK = REG_W'(1) << MSS_BIT;

  typedef struct packed {
    logic wrEse;
    logic wrSre;
    logic wrPsc;
    logic restore;
    logic zeroMasks;
    logic setPon;
    logic rdClear;
  } ctlStrobe_t;
endpackage

// File: rtl/evtstat_ctrl.sv
module evtstat_ctrl
  import evtstat_pkg::*;
(
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic             powerUpDone,
  input  logic             selftestOk,
  input  logic             manualMode,
  input  logic             evtRdEn,
  input  logic             pcFlag,
  output ctlStrobe_t       stb
);
  always_comb begin
    stb           = '0;
    stb.wrEse     = regWrEn && (regSel == SEL_ESE);
    stb.wrSre     = regWrEn && (regSel == SEL_SRE);
    stb.wrPsc     = regWrEn && (regSel == SEL_PSC);
    stb.restore   = powerUpDone;
    stb.zeroMasks = powerUpDone && pcFlag;
    stb.setPon    = powerUpDone && selftestOk && manualMode;
    stb.rdClear   = evtRdEn;
  end
endmodule

// File: rtl/evtstat_dp.sv
module evtstat_dp
  import evtstat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [N_PULSE-1:0] evtPulse,
  input  logic [REG_W-1:0]   wrData,
  input  logic [SEL_W-1:0]   regSel,
  output logic [REG_W-1:0]   evtReg,
  output logic [REG_W-1:0]   eseMask,
  output logic [REG_W-1:0]   sreMask,
  output logic               pcFlag,
  output logic [REG_W-1:0]   regRdData
);
  logic [REG_W-1:0] eseStore;
  logic [REG_W-1:0] sreStore;
  logic             pcStore;
  logic [REG_W-1:0] setVec;

  // Retained copy: no reset, survives the power cycle.
  always_ff @(posedge clk) begin
    if (stb.wrEse) eseStore <= wrData;
    if (stb.wrSre) sreStore <= wrData & ~MSS_MASK;
    if (stb.wrPsc) pcStore  <= wrData[0];
  end
  assign pcFlag = pcStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eseMask <= '0;
      sreMask <= '0;
    end else if (stb.restore) begin
      eseMask <= stb.zeroMasks ? '0 : eseStore;
      sreMask <= stb.zeroMasks ? '0 : sreStore;
    end else begin
      if (stb.wrEse) eseMask <= wrData;
      if (stb.wrSre) sreMask <= wrData & ~MSS_MASK;
    end
  end

  always_comb begin
    setVec                 = '0;
    setVec[N_PULSE-1:0]    = evtPulse;
    setVec[PON_BIT]        = stb.setPon;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_evt
    if (i == URQ_BIT) begin : g_urq
      assign evtReg[i] = 1'b0;
    end else begin : g_bit
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= (bitQ && !stb.rdClear) || setVec[i];
      end
      assign evtReg[i] = bitQ;
    end
  end

  always_comb begin
    case (regSel)
      SEL_ESE: regRdData = eseMask;
      SEL_SRE: regRdData = sreMask;
      SEL_PSC: regRdData = {{(REG_W-1){1'b0}}, pcFlag};
      default: regRdData = '0;
    endcase
  end

  p_cme_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[5] |=> evtReg[5]);
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdClear |=> ((evtReg & $past(evtReg)) == $past(evtReg)));
  p_psc_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restore && pcFlag) |=> (eseMask == '0 && sreMask == '0));
  p_restore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restore && !pcFlag) |=> (eseMask == $past(eseStore) && sreMask == $past(sreStore)));
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdClear && evtPulse == '0 && !stb.setPon) |=> (evtReg == '0));
endmodule

// File: rtl/evtstat_summary.sv
module evtstat_summary
  import evtstat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtReg,
  input  logic [REG_W-1:0] eseMask,
  input  logic [REG_W-1:0] sreMask,
  input  logic [REG_W-1:0] sbExtBits,
  output logic [REG_W-1:0] statusByte,
  output logic             srq
);
  logic             esb;
  logic             mss;
  logic [REG_W-1:0] sbLow;

  always_comb begin
    esb            = |(evtReg & eseMask);
    sbLow          = sbExtBits;
    sbLow[ESB_BIT] = esb;
    sbLow[MSS_BIT] = 1'b0;
    mss            = |(sbLow & sreMask & ~MSS_MASK);
    statusByte     = sbLow;
    statusByte[MSS_BIT] = mss;
    srq            = mss;
  end

  p_srq_bit5_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && sreMask[5]) |-> srq);
  p_srq_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[5] && ((sbExtBits & sreMask & 8'h9F) == '0)) |-> !srq);
  p_esb_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((evtReg & eseMask) == '0) |-> !statusByte[5]);
endmodule

// File: rtl/event_status_unit.sv
module event_status_unit
  import evtstat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_PULSE-1:0] evtPulse,
  input  logic               powerUpDone,
  input  logic               selftestOk,
  input  logic               manualMode,
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               evtRdEn,
  output logic [REG_W-1:0]   evtRdData,
  input  logic [REG_W-1:0]   sbExtBits,
  output logic [REG_W-1:0]   statusByte,
  output logic               srq
);
  ctlStrobe_t       stb;
  logic [REG_W-1:0] evtReg;
  logic [REG_W-1:0] eseMask;
  logic [REG_W-1:0] sreMask;
  logic             pcFlag;

  evtstat_ctrl u_ctrl (
    .regWrEn(regWrEn), .regSel(regSel), .powerUpDone(powerUpDone),
    .selftestOk(selftestOk), .manualMode(manualMode), .evtRdEn(evtRdEn),
    .pcFlag(pcFlag), .stb(stb)
  );

  evtstat_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evtPulse(evtPulse), .wrData(regWrData),
    .regSel(regSel), .evtReg(evtReg), .eseMask(eseMask), .sreMask(sreMask),
    .pcFlag(pcFlag), .regRdData(regRdData)
  );

  evtstat_summary u_sum (
    .clk(clk), .rstN(rstN), .evtReg(evtReg), .eseMask(eseMask), .sreMask(sreMask),
    .sbExtBits(sbExtBits), .statusByte(statusByte), .srq(srq)
  );

  assign evtRdData = evtReg;

  p_pon_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtRdData[7]) |-> $past(powerUpDone && selftestOk && manualMode));
endmodule

// File: tb/sim_event_status_unit.sv
`timescale 1ns/1ps
module sim_event_status_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtPulse = '0;
  logic       powerUpDone = 1'b0, selftestOk = 1'b0, manualMode = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       evtRdEn = 1'b0;
  logic [7:0] evtRdData;
  logic [7:0] sbExtBits = '0;
  logic [7:0] statusByte;
  logic       srq;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  event_status_unit u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .powerUpDone(powerUpDone),
    .selftestOk(selftestOk), .manualMode(manualMode), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .evtRdEn(evtRdEn), .evtRdData(evtRdData), .sbExtBits(sbExtBits),
    .statusByte(statusByte), .srq(srq)
  );

  // {pulse[5:0], read, expected event reg, expected sb5, expected srq}
  localparam logic [16:0] VECS [0:9] = '{
    {6'h01, 1'b0, 8'h01, 1'b1, 1'b1},
    {6'h20, 1'b0, 8'h21, 1'b1, 1'b1},
    {6'h00, 1'b1, 8'h00, 1'b0, 1'b0},
    {6'h04, 1'b0, 8'h04, 1'b1, 1'b1},
    {6'h10, 1'b1, 8'h10, 1'b1, 1'b1},
    {6'h0A, 1'b0, 8'h1A, 1'b1, 1'b1},
    {6'h00, 1'b0, 8'h1A, 1'b1, 1'b1},
    {6'h00, 1'b1, 8'h00, 1'b0, 1'b0},
    {6'h3F, 1'b0, 8'h3F, 1'b1, 1'b1},
    {6'h00, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] d);
    regSel = sel; #0.5; d = regRdData;
  endtask

  task automatic pulse(input logic [5:0] p);
    evtPulse = p; tick(); evtPulse = '0;
  endtask

  task automatic readEvt(output logic [7:0] d);
    evtRdEn = 1'b1; #0.5; d = evtRdData;
    tick(); evtRdEn = 1'b0;
  endtask

  task automatic powerUp(input logic ok, input logic man);
    selftestOk = ok; manualMode = man; powerUpDone = 1'b1;
    tick(); powerUpDone = 1'b0;
  endtask

  task automatic powerCycle();
    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    logic [7:0] d;
    tick(); tick();
    chk("R1 reset event reg", evtRdData, 8'h00);
    chk("R6 reset status byte", statusByte, 8'h00);
    chk("R10 reset srq", {7'b0, srq}, 8'h00);
    rstN = 1'b1; tick();

    // R11 register port
    wrReg(2'd0, 8'hA5); rdReg(2'd0, d); chk("R11 ese readback", d, 8'hA5);
    wrReg(2'd1, 8'hFF); rdReg(2'd1, d); chk("R9 sre bit6 reads 0", d, 8'hBF);
    wrReg(2'd3, 8'h77); rdReg(2'd3, d); chk("R11 sel3 reads 0", d, 8'h00);
    rdReg(2'd0, d); chk("R11 sel3 write ignored ese", d, 8'hA5);

    // vector walk: ese=FF, sre=20
    wrReg(2'd0, 8'hFF); wrReg(2'd1, 8'h20); readEvt(d);
    for (int i = 0; i < 10; i++) begin
      evtPulse = VECS[i][16:11]; evtRdEn = VECS[i][10];
      tick();
      evtPulse = '0; evtRdEn = 1'b0;
      chk("R1/R8 vector event reg", evtRdData, VECS[i][9:2]);
      chk("R6 vector sb5", {7'b0, statusByte[5]}, {7'b0, VECS[i][1]});
      chk("R7/R10 vector srq", {7'b0, srq}, {7'b0, VECS[i][0]});
      chk("R2 vector bit6", {7'b0, evtRdData[6]}, 8'h00);
    end

    // R8 read returns old value
    pulse(6'h22); readEvt(d); chk("R8 read returns value", d, 8'h22);
    chk("R8 cleared after read", evtRdData, 8'h00);

    // R6 mask selectivity
    wrReg(2'd0, 8'h01); pulse(6'h02);
    chk("R6 unmasked bit no summary", {7'b0, statusByte[5]}, 8'h00);
    pulse(6'h01);
    chk("R6 masked bit summary", {7'b0, statusByte[5]}, 8'h01);
    chk("R7 srq from sb5", {7'b0, srq}, 8'h01);
    // R10 clear mask bit -> srq falls
    wrReg(2'd1, 8'h00);
    chk("R10 srq falls on mask clear", {7'b0, srq}, 8'h00);
    readEvt(d);

    // R9 master summary from external bits
    sbExtBits = 8'h01; wrReg(2'd1, 8'h01); #0.5;
    chk("R9 mss from ext bit", statusByte, 8'h41);
    chk("R9 srq from ext bit", {7'b0, srq}, 8'h01);
    wrReg(2'd1, 8'h40); #0.5;
    chk("R9 sre bit6 ignored", statusByte, 8'h01);
    chk("R10 srq low with only bit6", {7'b0, srq}, 8'h00);
    sbExtBits = 8'h00;

    // R3 power-on qualification
    powerUp(1'b0, 1'b1); chk("R3 failed selftest no PON", evtRdData, 8'h00);
    powerUp(1'b1, 1'b0); chk("R3 non-manual no PON", evtRdData, 8'h00);
    powerUp(1'b1, 1'b1); chk("R3 PON set", evtRdData, 8'h80);
    readEvt(d);

    // R5 masks survive power cycle
    wrReg(2'd0, 8'h80); wrReg(2'd1, 8'h20); wrReg(2'd2, 8'h00);
    powerCycle();
    rdReg(2'd0, d); chk("R5 live ese cleared by reset", d, 8'h00);
    powerUp(1'b1, 1'b1);
    rdReg(2'd0, d); chk("R5 ese restored", d, 8'h80);
    rdReg(2'd1, d); chk("R5 sre restored", d, 8'h20);
    chk("R5 PON after cycle", evtRdData, 8'h80);
    chk("R7 srq after power cycle", {7'b0, srq}, 8'h01);
    readEvt(d);
    chk("R10 srq falls after read", {7'b0, srq}, 8'h00);

    // R4 power-on clear
    wrReg(2'd2, 8'h01);
    powerCycle();
    powerUp(1'b1, 1'b1);
    rdReg(2'd0, d); chk("R4 ese zeroed", d, 8'h00);
    rdReg(2'd1, d); chk("R4 sre zeroed", d, 8'h00);
    rdReg(2'd2, d); chk("R11 pc flag readback", d, 8'h01);
    chk("R4 PON still latched", evtRdData, 8'h80);
    chk("R4 no summary", {7'b0, statusByte[5]}, 8'h00);
    chk("R4 no srq", {7'b0, srq}, 8'h00);

    finishRun();
  end
endmodule